// File: doc/BRIEF.md
# Leveled Interrupt Acceptance Controller

This block sits between a set of peripheral interrupt request lines and a processor core. Each source carries a 2-bit priority level, where a smaller number means a more urgent request and the value 3 switches the source off. Every cycle the block picks the most urgent pending request and checks it against the core's current interrupt level and global enable. A request that passes is offered to the core as a vector index together with its level.

When the core takes the offer, the block saves the current level on a small internal save stack and raises the current level to the accepted one. A return strobe pops the stack and restores the saved level. Request lines are level signals owned by the peripherals: the block never clears them. A request that is still set after its handler starts is therefore blocked by the raised level until the return. A separate wake output tells the power controller that an enabled request is pending, whether or not interrupts are enabled.

The offer to the core is a valid/ready interface. Once `ent_valid` is high, `ent_vec` and `ent_lvl` stay frozen and `ent_valid` stays high until the core raises `ent_ready`. The core may hold `ent_ready` low for any number of cycles. The offer is committed: a request that drops while it waits does not withdraw it. After a transfer, at least one cycle passes before the next offer, so that the next winner is judged against the new level.

Top module: `irq_accept_ctrl`

## Requirements
- R1: Among pending sources with level 0..2, the offer carries the lowest level. Among sources at that level, it carries the lowest source index, and `ent_vec` equals that index.
- R2: A source whose level field is 3 is never offered and does not assert `wake`.
- R3: An offer is raised only when the winner's level is strictly below `cur_lvl`. A request at the same or a larger level waits.
- R4: While `int_en` is 0, no new offer is raised. Pending requests stay pending.
- R5: While `ent_valid` is 1 and `ent_ready` is 0, `ent_valid`, `ent_vec` and `ent_lvl` keep their values, even if the request drops.
- R6: On a transfer (`ent_valid` and `ent_ready` both 1 at a clock edge), `cur_lvl` takes the offered level on that edge, and the previous `cur_lvl` is saved on the stack.
- R7: A `ret_strobe` cycle restores `cur_lvl` to the most recently saved level. With an empty stack the strobe leaves `cur_lvl` unchanged.
- R8: The block never clears requests. A source still requesting after its handler was entered is offered again once a return lowers the level far enough.
- R9: `wake` is 1 in the same cycle that any source has its request set and a level of 0..2, independent of `int_en`.
- R10: A transfer while the stack already holds STACK_DEPTH entries sets `nest_ovf`. The flag then stays 1 until reset.
- R11: After reset, `cur_lvl` is 3 and both `ent_valid` and `nest_ovf` are 0.
- R12: A transfer and a return in the same cycle give `cur_lvl` the offered level, and the entry below is kept. A later return then restores that entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_SRC | Request flag per source, held by the peripheral |
| irq_lvl | input | 2*NUM_SRC | Level per source, source s at bits [2s+1:2s] |
| int_en | input | 1 | Global interrupt enable |
| ret_strobe | input | 1 | One-cycle return-from-handler pulse |
| ent_valid | output | 1 | Offer to the core is valid |
| ent_ready | input | 1 | Core takes the offer |
| ent_vec | output | IDX_W | Vector index (winning source) |
| ent_lvl | output | 2 | Level of the offered request |
| cur_lvl | output | 2 | Current interrupt level field |
| wake | output | 1 | Enabled request pending; ends standby |
| nest_ovf | output | 1 | Sticky save-stack overflow |

## Verification
The checker assumes that `ent_ready` only has meaning while `ent_valid` is high. It also assumes that the level inputs of a source are stable from the moment it is offered until the offer is taken. Its properties on offer stability and strict level ordering rely on the core not lowering `cur_lvl` by any path other than `ret_strobe`. The stimulus changes inputs only on falling edges and pulses `ret_strobe` for single cycles. It exercises overflow on a second instance whose stack is two entries deep, because with four levels a depth-4 stack can never fill.

// File: rtl/iac_pkg.sv
package iac_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_OFF = 2'd3;
  localparam int NUM_ACTIVE_LVL = 3;
endpackage

// File: rtl/iac_arbiter.sv
module iac_arbiter
  import iac_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0]       req,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
  output logic                     found,
  output logic [IDX_W-1:0]         win_idx,
  output lvl_t                     win_lvl,
  output logic                     any_live
);
  lvl_t               src_lvl [NUM_SRC];
  logic [NUM_SRC-1:0] live;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign src_lvl[s] = lvl_flat[s*LVL_W +: LVL_W];
    assign live[s]    = req[s] && (lvl_flat[s*LVL_W +: LVL_W] != LVL_OFF);
  end

  assign any_live = |live;

  // Most urgent level first, lowest index inside a level.
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = LVL_OFF;
    for (int l = 0; l < NUM_ACTIVE_LVL; l++) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (!found && live[s] && src_lvl[s] == lvl_t'(l)) begin
          found   = 1'b1;
          win_idx = IDX_W'(s);
          win_lvl = lvl_t'(l);
        end
      end
    end
  end
endmodule

// File: rtl/iac_save_stack.sv
module iac_save_stack
  import iac_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  lvl_t push_data,
  output lvl_t top,
  output logic empty,
  output logic ovf
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  lvl_t             mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic             full;

  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_W'(DEPTH));
  assign top   = empty ? LVL_OFF : mem[cnt - 1'b1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (push && pop && !empty) begin
      mem[cnt - 1'b1] <= push_data;
    end else if (pop && !empty) begin
      cnt <= cnt - 1'b1;
    end else if (push) begin
      if (full) begin
        ovf <= 1'b1;
      end else begin
        mem[cnt] <= push_data;
        cnt      <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/iac_offer.sv
module iac_offer
  import iac_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_vec,
  input  lvl_t             load_lvl,
  input  logic             take,
  output logic             valid,
  output logic [IDX_W-1:0] vec,
  output lvl_t             lvl
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      vec   <= '0;
      lvl   <= LVL_OFF;
    end else if (take) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      vec   <= load_vec;
      lvl   <= load_lvl;
    end
  end
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import iac_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int STACK_DEPTH = 4,
  localparam int IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       irq_req,
  input  logic [NUM_SRC*LVL_W-1:0] irq_lvl,
  input  logic                     int_en,
  input  logic                     ret_strobe,
  output logic                     ent_valid,
  input  logic                     ent_ready,
  output logic [IDX_W-1:0]         ent_vec,
  output logic [LVL_W-1:0]         ent_lvl,
  output logic [LVL_W-1:0]         cur_lvl,
  output logic                     wake,
  output logic                     nest_ovf
);
  logic             found;
  logic [IDX_W-1:0] win_idx;
  lvl_t             win_lvl;
  lvl_t             stk_top;
  logic             stk_empty;
  logic             take, ret_eff, load;
  lvl_t             cur_q;

  iac_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .req(irq_req), .lvl_flat(irq_lvl), .found(found),
    .win_idx(win_idx), .win_lvl(win_lvl), .any_live(wake)
  );

  assign take    = ent_valid && ent_ready;
  assign ret_eff = ret_strobe && !stk_empty;
  assign load    = !ent_valid && found && int_en && (win_lvl < cur_q);

  iac_offer #(.IDX_W(IDX_W)) u_offer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_vec(win_idx),
    .load_lvl(win_lvl), .take(take), .valid(ent_valid),
    .vec(ent_vec), .lvl(ent_lvl)
  );

  // Same-cycle return and entry: the restored level is what gets saved.
  iac_save_stack #(.DEPTH(STACK_DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(take), .pop(ret_eff),
    .push_data(ret_eff ? stk_top : cur_q), .top(stk_top),
    .empty(stk_empty), .ovf(nest_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       cur_q <= LVL_OFF;
    else if (take)    cur_q <= ent_lvl;
    else if (ret_eff) cur_q <= stk_top;
  end

  assign cur_lvl = cur_q;
endmodule

// File: rtl/iac_chk.sv
module iac_chk #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irq_req,
  input logic               int_en,
  input logic               ent_valid,
  input logic               ent_ready,
  input logic [IDX_W-1:0]   ent_vec,
  input logic [1:0]         ent_lvl,
  input logic [1:0]         cur_lvl,
  input logic               wake,
  input logic               nest_ovf
);
  p_offer_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && !ent_ready |=> ent_valid && $stable(ent_vec) && $stable(ent_lvl));

  p_offer_beats_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> ent_lvl < cur_lvl);

  p_no_off_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> ent_lvl != 2'd3);

  p_enable_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ent_valid) |-> $past(int_en));

  p_take_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && ent_ready |=> cur_lvl == $past(ent_lvl) && !ent_valid);

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    nest_ovf |=> nest_ovf);

  p_quiet_no_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == '0 |-> !wake);
endmodule

bind irq_accept_ctrl iac_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .int_en(int_en),
  .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_vec(ent_vec),
  .ent_lvl(ent_lvl), .cur_lvl(cur_lvl), .wake(wake), .nest_ovf(nest_ovf)
);

// File: tb/test_irq_accept_ctrl.sv
module test_irq_accept_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // Instance A: defaults (8 sources, depth 4)
  logic [7:0]  a_req = '0;
  logic [15:0] a_lvl = '1;
  logic        a_en = 1'b0, a_ret = 1'b0, a_rdy = 1'b0;
  logic        a_val, a_wake, a_ovf;
  logic [2:0]  a_vec;
  logic [1:0]  a_elvl, a_cur;

  irq_accept_ctrl i_irq_accept_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(a_req), .irq_lvl(a_lvl), .int_en(a_en),
    .ret_strobe(a_ret), .ent_valid(a_val), .ent_ready(a_rdy), .ent_vec(a_vec),
    .ent_lvl(a_elvl), .cur_lvl(a_cur), .wake(a_wake), .nest_ovf(a_ovf)
  );

  // Instance B: 4 sources, depth 2, for overflow
  logic [3:0] b_req = '0;
  logic [7:0] b_lvl = '1;
  logic       b_en = 1'b0, b_rdy = 1'b0;
  logic       b_val, b_wake, b_ovf;
  logic [1:0] b_vec, b_elvl, b_cur;

  irq_accept_ctrl #(.NUM_SRC(4), .STACK_DEPTH(2)) i_irq_accept_ctrl_b (
    .clk(clk), .rst_n(rst_n), .irq_req(b_req), .irq_lvl(b_lvl), .int_en(b_en),
    .ret_strobe(1'b0), .ent_valid(b_val), .ent_ready(b_rdy), .ent_vec(b_vec),
    .ent_lvl(b_elvl), .cur_lvl(b_cur), .wake(b_wake), .nest_ovf(b_ovf)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_a(input int s, input bit r, input logic [1:0] l);
    a_req[s] = r;
    a_lvl[s*2 +: 2] = l;
  endtask

  // Scoreboard of expected transfers on instance A
  int exp_q[$];

  task automatic take_a(input int vec, input int lvl);
    exp_q.push_back(vec * 4 + lvl);
    a_rdy = 1'b1;
    tick();
    a_rdy = 1'b0;
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && a_val && a_rdy) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected transfer", a_vec * 4 + a_elvl, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(a_vec * 4 + a_elvl == e, "R1 transfer vec*4+lvl", a_vec * 4 + a_elvl, e);
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    // R11 reset state
    chk(a_cur == 2'd3, "R11 cur_lvl", a_cur, 3);
    chk(!a_val, "R11 ent_valid", a_val, 0);
    chk(!a_ovf, "R11 nest_ovf", a_ovf, 0);

    // R2: level-3 source neither offered nor waking
    a_en = 1'b1;
    set_a(5, 1'b1, 2'd3);
    tick(3);
    chk(!a_val, "R2 off-level offered", a_val, 0);
    chk(!a_wake, "R2 off-level wake", a_wake, 0);
    set_a(5, 1'b0, 2'd3);

    // R4 / R9: disabled but pending
    a_en = 1'b0;
    set_a(2, 1'b1, 2'd1);
    set_a(6, 1'b1, 2'd0);
    set_a(4, 1'b1, 2'd0);
    tick();
    chk(a_wake, "R9 wake while disabled", a_wake, 1);
    tick(3);
    chk(!a_val, "R4 no offer while disabled", a_val, 0);

    // R1: lowest level, then lowest index (4 beats 6)
    a_en = 1'b1;
    tick();
    chk(a_val && a_vec == 3'd4, "R1 winner index", a_vec, 4);
    chk(a_elvl == 2'd0, "R1 winner level", a_elvl, 0);

    // R5: hold while not ready, even with request dropped
    set_a(4, 1'b0, 2'd0);
    tick(3);
    chk(a_val && a_vec == 3'd4, "R5 offer held", a_vec, 4);

    // R6: transfer raises level
    take_a(4, 0);
    chk(a_cur == 2'd0, "R6 cur_lvl after take", a_cur, 0);
    tick(3);
    chk(!a_val, "R3 equal level blocked", a_val, 0);

    // R7: return restores 3, then src6 offered
    a_ret = 1'b1; tick(); a_ret = 1'b0;
    chk(a_cur == 2'd3, "R7 restore", a_cur, 3);
    tick();
    chk(a_val && a_vec == 3'd6, "R1 next winner", a_vec, 6);
    take_a(6, 0);
    set_a(6, 1'b0, 2'd0);
    a_ret = 1'b1; tick(); a_ret = 1'b0;
    tick();
    take_a(2, 1);
    chk(a_cur == 2'd1, "R6 cur after level-1 take", a_cur, 1);
    tick(3);
    chk(!a_val, "R8 still-set request held off", a_val, 0);

    // R3: strictly lower level nests
    set_a(3, 1'b1, 2'd0);
    tick();
    chk(a_val && a_vec == 3'd3, "R3 nested offer", a_vec, 3);
    take_a(3, 0);
    set_a(3, 1'b0, 2'd0);
    a_ret = 1'b1; tick(); a_ret = 1'b0;
    chk(a_cur == 2'd1, "R7 restores most recent", a_cur, 1);
    tick(2);
    chk(!a_val, "R3 level-1 blocked at level 1", a_val, 0);
    a_ret = 1'b1; tick(); a_ret = 1'b0;
    tick();
    chk(a_val && a_vec == 3'd2, "R8 re-offer after return", a_vec, 2);
    take_a(2, 1);

    // R12: return and transfer in the same cycle
    set_a(0, 1'b1, 2'd0);
    tick();
    chk(a_val && a_vec == 3'd0, "R12 offer pending", a_vec, 0);
    exp_q.push_back(0);
    a_rdy = 1'b1; a_ret = 1'b1;
    tick();
    a_rdy = 1'b0; a_ret = 1'b0;
    chk(a_cur == 2'd0, "R12 cur takes offer", a_cur, 0);
    set_a(0, 1'b0, 2'd0);
    set_a(2, 1'b0, 2'd1);
    a_ret = 1'b1; tick(); a_ret = 1'b0;
    chk(a_cur == 2'd3, "R12 entry below kept", a_cur, 3);
    a_ret = 1'b1; tick(); a_ret = 1'b0;
    chk(a_cur == 2'd3, "R7 empty-stack return", a_cur, 3);
    chk(!a_ovf, "R10 no overflow at depth 4", a_ovf, 0);
    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);

    // R10: overflow on depth-2 instance
    b_en = 1'b1;
    b_req[0] = 1'b1; b_lvl[1:0] = 2'd2;
    tick();
    b_rdy = 1'b1; tick(); b_rdy = 1'b0;
    b_req[1] = 1'b1; b_lvl[3:2] = 2'd1;
    tick();
    b_rdy = 1'b1; tick(); b_rdy = 1'b0;
    chk(!b_ovf && b_cur == 2'd1, "R10 two entries no overflow", b_ovf, 0);
    b_req[2] = 1'b1; b_lvl[5:4] = 2'd0;
    tick();
    chk(b_val && b_vec == 2'd2, "R1 instance b winner", b_vec, 2);
    b_rdy = 1'b1; tick(); b_rdy = 1'b0;
    chk(b_ovf, "R10 overflow set", b_ovf, 1);
    chk(b_cur == 2'd0, "R10 level still raised", b_cur, 0);
    b_req = '0;
    tick(3);
    chk(b_ovf, "R10 overflow sticky", b_ovf, 1);

    finish_run();
  end
endmodule